// File: doc/BRIEF.md
# Streaming Absolute-Difference Box Aggregator

This block takes two pixel streams from a stereo camera pair, one pixel of each image per beat, for a single candidate disparity `d`. For every column `x` of the reference (right) image it forms the cost `|R[x] - L[x+d]|`. It then produces two rectangular window sums of that cost, a large side window and a smaller centre window. Both sums use running totals: the newest element is added and the one leaving the window is subtracted, first along the scanline and then down the columns. The vertical step keeps per-column histories of earlier row sums in line memories.

A disparity search runs the block once per candidate value and combines the scores downstream. Streams on both sides use valid/ready handshakes. A line marker and a frame marker travel with the first beat of each scanline and of each frame. The disparity is captured on the frame-marker beat and holds for the whole frame.

Top module: `sad_box_aggregator`

## Requirements
- R1: The cost for output column x is the absolute difference of the right pixel at x and the left pixel at x+d, where d is the `disp` value sampled on the input beat that carries `in_sof`.
- R2: Every line of IMG_W input beats yields exactly IMG_W output beats. Columns with x+d ≥ IMG_W have cost 0. While these d padding columns are produced after the last input of a line, `in_ready` is low.
- R3: `out_side` is the sum of costs over the WIN_H columns ending at x and the WIN_V lines ending at the current line. The accumulator widths hold WIN_H·WIN_V maximum costs without wrapping.
- R4: `out_ctr` is the same kind of sum over 2·CWIN_H columns and 2·CWIN_V lines.
- R5: Horizontal sums restart at column 0 of each line, and vertical sums restart at line 0 of each frame. Before a window has filled, the score sums only the columns and lines seen so far.
- R6: `out_side_ok` is 1 exactly when x ≥ WIN_H−1 and the line index ≥ WIN_V−1. `out_ctr_ok` is 1 exactly when x ≥ 2·CWIN_H−1 and the line index ≥ 2·CWIN_V−1.
- R7: While `out_valid` is 1 and `out_ready` is 0, every output holds its value. No output beat is lost or repeated.
- R8: `out_sol` is 1 on output column 0 of every line. `out_sof` is 1 only on column 0 of line 0.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| disp | input | DW | Candidate disparity, sampled with `in_sof` |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with `in_valid` |
| in_sof | input | 1 | First beat of a frame |
| in_sol | input | 1 | First beat of a line |
| in_right | input | PIX_W | Right-image pixel at the input column |
| in_left | input | PIX_W | Left-image pixel at the input column |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_sof | output | 1 | Output beat is column 0 of line 0 |
| out_sol | output | 1 | Output beat is column 0 of a line |
| out_side | output | SS_W | Side-window score |
| out_ctr | output | SC_W | Centre-window score |
| out_side_ok | output | 1 | Side window fully populated |
| out_ctr_ok | output | 1 | Centre window fully populated |

## Verification
The bench builds the block with IMG_W=12, DMAX=4, WIN_H=4, WIN_V=3, CWIN_H=1 and CWIN_V=1. With these values a five-line frame crosses every fill boundary of both windows. The largest disparity pads a third of each line, so padding, restart and fully populated windows all appear within a few hundred beats. The centre window has a different span from the side window in both directions, so a mix-up between the two recurrences shows up. An all-maximum frame with d=0 drives the side accumulator to its peak value.

// File: rtl/sad_box_aggregator.sv
module sad_box_aggregator #(
  parameter int IMG_W  = 64,
  parameter int DMAX   = 16,
  parameter int PIX_W  = 8,
  parameter int WIN_H  = 23,
  parameter int WIN_V  = 7,
  parameter int CWIN_H = 7,
  parameter int CWIN_V = 3,
  parameter int LINE_W = 12,
  localparam int DW    = $clog2(DMAX + 1),
  localparam int CH    = 2 * CWIN_H,
  localparam int CV    = 2 * CWIN_V,
  localparam int SS_W  = PIX_W + $clog2(WIN_H * WIN_V + 1),
  localparam int SC_W  = PIX_W + $clog2(CH * CV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    disp,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic             in_sol,
  input  logic [PIX_W-1:0] in_right,
  input  logic [PIX_W-1:0] in_left,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sof,
  output logic             out_sol,
  output logic [SS_W-1:0]  out_side,
  output logic [SC_W-1:0]  out_ctr,
  output logic             out_side_ok,
  output logic             out_ctr_ok
);
  localparam int HD   = (WIN_H > CH) ? WIN_H : CH;
  localparam int XW   = $clog2(IMG_W);
  localparam int VW   = $clog2(IMG_W + DMAX + 1);
  localparam int RS_W = PIX_W + $clog2(WIN_H + 1);
  localparam int RC_W = PIX_W + $clog2(CH + 1);
  localparam int SLS  = $clog2(WIN_V + 1);
  localparam int SLC  = $clog2(CV + 1);
  localparam int AS_W = $clog2(WIN_V * IMG_W + 1);
  localparam int AC_W = $clog2(CV * IMG_W + 1);

  logic [PIX_W-1:0] rhist [DMAX];
  logic [PIX_W-1:0] chist [HD];
  logic [SS_W-1:0]  vsum_s [IMG_W];
  logic [SC_W-1:0]  vsum_c [IMG_W];
  logic [RS_W-1:0]  rows_s [WIN_V * IMG_W];
  logic [RC_W-1:0]  rows_c [CV * IMG_W];

  logic [RS_W-1:0] hs;
  logic [RC_W-1:0] hc;
  logic [VW-1:0]   col;
  logic [DW-1:0]   dreg, fl_cnt;
  logic [LINE_W-1:0] yl;
  logic [SLS-1:0]  slot_s;
  logic [SLC-1:0]  slot_c;

  wire can_adv  = !out_valid || out_ready;
  wire flushing = fl_cnt != '0;
  assign in_ready = can_adv && !flushing;
  wire take     = in_valid && in_ready;
  wire step     = take || (can_adv && flushing);
  wire line_beg = take && (in_sol || in_sof);
  wire frm_beg  = take && in_sof;

  wire [DW-1:0] d_eff = frm_beg ? disp : dreg;
  wire [VW-1:0] vcol  = line_beg ? '0 : col;
  wire emit = step && (vcol >= VW'(d_eff));
  wire [XW-1:0] xcol = XW'(vcol - VW'(d_eff));

  wire [LINE_W-1:0] y_eff = frm_beg ? '0 :
                            (line_beg && yl != '1) ? yl + 1'b1 : yl;
  wire [SLS-1:0] ss_eff = frm_beg ? '0 :
                          line_beg ? ((slot_s == SLS'(WIN_V - 1)) ? '0 : slot_s + 1'b1) : slot_s;
  wire [SLC-1:0] sc_eff = frm_beg ? '0 :
                          line_beg ? ((slot_c == SLC'(CV - 1)) ? '0 : slot_c + 1'b1) : slot_c;

  wire [PIX_W-1:0] rsel = (d_eff == '0) ? in_right : rhist[d_eff - 1'b1];
  wire [PIX_W-1:0] cost = flushing ? '0 :
                          (rsel > in_left) ? rsel - in_left : in_left - rsel;

  wire [RS_W-1:0] hs_next = ((xcol == '0) ? '0 : hs) + RS_W'(cost)
                          - ((32'(xcol) >= WIN_H) ? RS_W'(chist[WIN_H-1]) : '0);
  wire [RC_W-1:0] hc_next = ((xcol == '0) ? '0 : hc) + RC_W'(cost)
                          - ((32'(xcol) >= CH) ? RC_W'(chist[CH-1]) : '0);

  wire [AS_W-1:0] as_idx = AS_W'(ss_eff) * AS_W'(IMG_W) + AS_W'(xcol);
  wire [AC_W-1:0] ac_idx = AC_W'(sc_eff) * AC_W'(IMG_W) + AC_W'(xcol);

  wire [SS_W-1:0] old_s = (32'(y_eff) >= WIN_V) ? SS_W'(rows_s[as_idx]) : '0;
  wire [SC_W-1:0] old_c = (32'(y_eff) >= CV) ? SC_W'(rows_c[ac_idx]) : '0;
  wire [SS_W-1:0] vs_next = ((y_eff == '0) ? '0 : vsum_s[xcol]) + SS_W'(hs_next) - old_s;
  wire [SC_W-1:0] vc_next = ((y_eff == '0) ? '0 : vsum_c[xcol]) + SC_W'(hc_next) - old_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0; dreg <= '0; fl_cnt <= '0; yl <= '0;
      slot_s <= '0; slot_c <= '0; hs <= '0; hc <= '0;
      out_valid <= 1'b0; out_sof <= 1'b0; out_sol <= 1'b0;
      out_side <= '0; out_ctr <= '0; out_side_ok <= 1'b0; out_ctr_ok <= 1'b0;
    end else begin
      if (step) begin
        col <= vcol + 1'b1;
        if (take && vcol == VW'(IMG_W - 1)) fl_cnt <= d_eff;
        else if (flushing) fl_cnt <= fl_cnt - 1'b1;
      end
      if (frm_beg) dreg <= disp;
      if (take) begin
        yl <= y_eff; slot_s <= ss_eff; slot_c <= sc_eff;
      end
      if (emit) begin
        hs <= hs_next; hc <= hc_next;
        out_side <= vs_next; out_ctr <= vc_next;
        out_sol <= xcol == '0;
        out_sof <= xcol == '0 && y_eff == '0;
        out_side_ok <= 32'(xcol) >= WIN_H - 1 && 32'(y_eff) >= WIN_V - 1;
        out_ctr_ok <= 32'(xcol) >= CH - 1 && 32'(y_eff) >= CV - 1;
        out_valid <= 1'b1;
      end else if (out_ready) out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (step) begin
      rhist[0] <= in_right;
      for (int k = 1; k < DMAX; k++) rhist[k] <= rhist[k-1];
    end
    if (emit) begin
      chist[0] <= cost;
      for (int k = 1; k < HD; k++) chist[k] <= chist[k-1];
      vsum_s[xcol] <= vs_next;
      vsum_c[xcol] <= vc_next;
      rows_s[as_idx] <= hs_next;
      rows_c[ac_idx] <= hc_next;
    end
  end
endmodule

// File: rtl/sad_box_aggregator_chk.sv
module sad_box_aggregator_chk #(
  parameter int PIX_W = 8, parameter int WIN_H = 23, parameter int WIN_V = 7,
  parameter int CWIN_H = 7, parameter int CWIN_V = 3,
  parameter int SS_W = 16, parameter int SC_W = 15
) (
  input logic clk, input logic rst_n,
  input logic in_ready, input logic out_valid, input logic out_ready,
  input logic out_sof, input logic out_sol,
  input logic [SS_W-1:0] out_side, input logic [SC_W-1:0] out_ctr,
  input logic out_side_ok, input logic out_ctr_ok
);
  localparam longint MAXS = ((64'd1 << PIX_W) - 1) * WIN_H * WIN_V;
  localparam longint MAXC = ((64'd1 << PIX_W) - 1) * 4 * CWIN_H * CWIN_V;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_side) && $stable(out_ctr)
                                 && $stable(out_sol) && $stable(out_sof));
  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> 64'(out_side) <= MAXS);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> 64'(out_ctr) <= MAXC);
  assert_sof_sol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> out_sol);
  assert_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sol && WIN_H > 1 |-> !out_side_ok);
  assert_fillc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> !out_ctr_ok);
endmodule

bind sad_box_aggregator sad_box_aggregator_chk #(
  .PIX_W(PIX_W), .WIN_H(WIN_H), .WIN_V(WIN_V), .CWIN_H(CWIN_H), .CWIN_V(CWIN_V),
  .SS_W(SS_W), .SC_W(SC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sof(out_sof), .out_sol(out_sol),
  .out_side(out_side), .out_ctr(out_ctr),
  .out_side_ok(out_side_ok), .out_ctr_ok(out_ctr_ok)
);

// File: tb/sim_sad_box_aggregator.sv
`timescale 1ns/1ps
module sim_sad_box_aggregator;
  localparam int W = 12, DM = 4, WH = 4, WV = 3, CWH = 1, CWV = 1;
  localparam int H = 5, NF = 6;
  localparam int DW = $clog2(DM + 1);
  localparam int SS_W = 8 + $clog2(WH * WV + 1);
  localparam int SC_W = 8 + $clog2(4 * CWH * CWV + 1);

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] disp = '0;
  logic in_valid = 0, in_sof = 0, in_sol = 0, out_ready = 0;
  logic [7:0] in_right = '0, in_left = '0;
  logic in_ready, out_valid, out_sof, out_sol, out_side_ok, out_ctr_ok;
  logic [SS_W-1:0] out_side;
  logic [SC_W-1:0] out_ctr;

  always #4 clk = ~clk;

  sad_box_aggregator #(.IMG_W(W), .DMAX(DM), .PIX_W(8), .WIN_H(WH), .WIN_V(WV),
    .CWIN_H(CWH), .CWIN_V(CWV), .LINE_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .disp(disp), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_sol(in_sol), .in_right(in_right), .in_left(in_left),
    .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof), .out_sol(out_sol),
    .out_side(out_side), .out_ctr(out_ctr), .out_side_ok(out_side_ok), .out_ctr_ok(out_ctr_ok));

  int rimg [NF][H][W];
  int limg [NF][H][W];
  int dsp [NF];
  int nchk = 0, nerr = 0;

  task automatic chk(string tag, int act, int exp, int f, int y, int x);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s frame=%0d y=%0d x=%0d actual=%0d expected=%0d", tag, f, y, x, act, exp);
    end
  endtask

  function automatic int cost_f(int f, int y, int x);
    int d = dsp[f];
    if (x + d >= W) return 0;
    return (rimg[f][y][x] > limg[f][y][x+d]) ? rimg[f][y][x] - limg[f][y][x+d]
                                              : limg[f][y][x+d] - rimg[f][y][x];
  endfunction

  function automatic int box_f(int f, int y, int x, int bh, int bv);
    int s = 0;
    for (int r = (y - bv + 1 < 0 ? 0 : y - bv + 1); r <= y; r++)
      for (int c = (x - bh + 1 < 0 ? 0 : x - bh + 1); c <= x; c++)
        s += cost_f(f, r, c);
    return s;
  endfunction

  bit timeout = 0;
  initial begin
    repeat (50000) @(posedge clk);
    timeout = 1;
  end

  int pf = 0, py = 0, px = 0;
  int mf = 0, my = 0, mx = 0;
  bit in_fire = 0, held = 0, in_done = 0;
  logic [SS_W-1:0] h_side;
  logic [SC_W-1:0] h_ctr;
  logic h_sol, h_sof;

  initial begin
    void'($urandom(32'd7));
    for (int f = 0; f < NF; f++) begin
      dsp[f] = (f == 0 || f == 2) ? 0 : (f == 1) ? DM : (f == 5) ? 1 : int'($urandom % (DM + 1));
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++) begin
          rimg[f][y][x] = (f == 0) ? 255 : int'($urandom % 256);
          limg[f][y][x] = (f == 0) ? 0 : (f == 2) ? rimg[f][y][x] : int'($urandom % 256);
        end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 out_valid", int'(out_valid), 0, 0, 0, 0);
    out_ready = 1; #1;
    chk("R9 in_ready", int'(in_ready), 1, 0, 0, 0);
    rst_n = 1;
    while (mf < NF && !timeout) begin
      @(negedge clk);
      if (in_fire) begin
        px++;
        if (px == W) begin px = 0; py++; end
        if (py == H) begin py = 0; pf++; end
        if (pf == NF) in_done = 1;
      end
      if (held) begin
        chk("R7 hold side", int'(out_side), int'(h_side), mf, my, mx);
        chk("R7 hold ctr", int'(out_ctr), int'(h_ctr), mf, my, mx);
        chk("R7 hold sol", int'(out_sol), int'(h_sol), mf, my, mx);
        chk("R7 hold valid", int'(out_valid), 1, mf, my, mx);
      end
      out_ready = ($urandom % 4) != 0;
      if (in_done) in_valid = 0;
      else begin
        if (!(in_valid && !in_fire)) in_valid = ($urandom % 4) != 0;
        in_right = 8'(rimg[pf][py][px]);
        in_left  = 8'(limg[pf][py][px]);
        in_sol = px == 0;
        in_sof = px == 0 && py == 0;
        disp = DW'(dsp[pf]);
      end
      #1;
      in_fire = in_valid && in_ready;
      held = out_valid && !out_ready;
      h_side = out_side; h_ctr = out_ctr; h_sol = out_sol; h_sof = out_sof;
      if (out_valid && out_ready) begin
        string tg;
        if (mx + dsp[mf] >= W) tg = "R2 pad side";
        else if (mx < WH - 1 || my < WV - 1) tg = "R5 partial side";
        else if (mf == 1) tg = "R1 side";
        else tg = "R3 side";
        chk(tg, int'(out_side), box_f(mf, my, mx, WH, WV), mf, my, mx);
        chk("R4 ctr", int'(out_ctr), box_f(mf, my, mx, 2 * CWH, 2 * CWV), mf, my, mx);
        chk("R6 side_ok", int'(out_side_ok), int'(mx >= WH - 1 && my >= WV - 1), mf, my, mx);
        chk("R6 ctr_ok", int'(out_ctr_ok), int'(mx >= 2 * CWH - 1 && my >= 2 * CWV - 1), mf, my, mx);
        chk("R8 sol", int'(out_sol), int'(mx == 0), mf, my, mx);
        chk("R8 sof", int'(out_sof), int'(mx == 0 && my == 0), mf, my, mx);
        mx++;
        if (mx == W) begin mx = 0; my++; end
        if (my == H) begin my = 0; mf++; end
      end
    end
    if (timeout) begin
      nchk++; nerr++;
      $display("FAIL R2 watchdog: beats frame=%0d y=%0d x=%0d expected frame=%0d", mf, my, mx, NF);
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule